// File: doc/BRIEF.md
# USB Full-Speed Packet Serializer

This block converts a stream of bytes into the differential line symbols of a USB full-speed (or low-speed) link. A writer pushes 9-bit words into a single-entry holding slot. Bit 8 flags the first byte of a packet, which is normally the sync value 0x80. A separate rate strobe, `bit_en`, marks the start of each bit period. On each strobe the block shifts the next bit out least-significant first. It inserts a stuffed zero after every run of six ones, applies NRZI coding, and drives D+/D- together with an output enable.

The writer keeps a packet going by refilling the holding slot whenever `buf_full` drops. When the shifter reaches a byte boundary and no byte is waiting, the block closes the packet by itself. It sends two SE0 periods and one J period, then releases the line to idle. CRC, packet field layout, receive and bus turnaround belong to other blocks.

Top module: `usbfs_serializer`

## Requirements
- R1: After reset, `line_dp`=1, `line_dm`=0, `line_oe`=0 and `buf_full`=0.
- R2: A write with `wr_data[8]`=1 accepted while the line is idle starts a packet at the next `bit_en`. With full-speed levels, the byte 0x80 appears as K,J,K,J,K,J,K,K.
- R3: Bits leave least significant first under NRZI. A 0 toggles the line between J and K, a 1 keeps it. The coder starts every packet from J.
- R4: After six consecutive 1 bits, counting across byte boundaries, one extra 0 is sent. The stuffed 0 consumes no data bit. It restarts the run count, and so does any data 0.
- R5: If the holding slot is empty when the last bit of a byte (and any stuffed bit after it) has gone out, the next three bit periods are SE0, SE0, J. The line then returns to idle with `line_oe`=0.
- R6: `buf_full` is 1 exactly while the holding slot holds a byte. A write while `buf_full`=1 is ignored and never reaches the line.
- R7: A write with `wr_data[8]`=0 while the line is idle is discarded at the next `bit_en` without any line activity.
- R8: Full-speed levels are J = (dp=1, dm=0) and K = (dp=0, dm=1). With `low_speed`=1 the two are swapped. SE0 is (0, 0) in both modes.
- R9: `line_oe` is 1 from the first sync bit period through the closing J period and 0 in idle. The idle level is J.
- R10: `line_dp`, `line_dm` and `line_oe` change only on the clock edge where `bit_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| low_speed | input | 1 | 1 selects low-speed line polarity |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Bit 8: packet start flag; bits 7:0: byte |
| buf_full | output | 1 | Holding slot occupied |
| line_dp | output | 1 | D+ level |
| line_dm | output | 1 | D- level |
| line_oe | output | 1 | Line driver enable |

## Verification
The assertions assume that `low_speed` changes only while the line is idle. They also assume that `bit_en` pulses are at least two clocks apart, so that every strobe's result is visible for a cycle before the next. The bench keeps `low_speed` fixed for each packet and spaces strobes four clocks apart. It refills the holding slot as soon as `buf_full` falls, so that only deliberate underruns end a packet. The sweep covers every byte value behind a sync byte, plus multi-byte runs whose stuffing crosses byte boundaries.

// File: rtl/usbfs_pkg.sv
package usbfs_pkg;

  typedef enum logic [1:0] {
    SYM_J   = 2'd0,
    SYM_K   = 2'd1,
    SYM_SE0 = 2'd2
  } line_sym_t;

  typedef enum logic [1:0] {
    CMD_REST = 2'd0,
    CMD_BIT  = 2'd1,
    CMD_SE0  = 2'd2,
    CMD_JEND = 2'd3
  } tx_cmd_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_SE0B = 2'd2,
    PH_JEND = 2'd3
  } tx_phase_t;

  // NRZI: a zero flips the line state, a one holds it
  function automatic line_sym_t nrzi_step(line_sym_t cur, logic bitv);
    line_sym_t nxt;
    if (bitv) nxt = cur;
    else      nxt = (cur == SYM_J) ? SYM_K : SYM_J;
    return nxt;
  endfunction

  // {dp, dm} for a symbol; low speed swaps the J/K polarity
  function automatic logic [1:0] sym_pins(line_sym_t s, logic ls);
    logic [1:0] p;
    case (s)
      SYM_J:   p = ls ? 2'b01 : 2'b10;
      SYM_K:   p = ls ? 2'b10 : 2'b01;
      default: p = 2'b00;
    endcase
    return p;
  endfunction

  // next length of the run of ones after sending a bit
  function automatic int unsigned ones_after(int unsigned run, logic bitv);
    return bitv ? run + 1 : 0;
  endfunction

endpackage

// File: rtl/usbfs_hold.sv
module usbfs_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W:0]   wr_data,
  input  logic              pop,
  output logic              valid,
  output logic              sop,
  output logic [BYTE_W-1:0] byte_q,
  output logic              accept
);

  assign accept = wr_en && !valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      sop    <= 1'b0;
      byte_q <= '0;
    end else if (accept) begin
      valid  <= 1'b1;
      sop    <= wr_data[BYTE_W];
      byte_q <= wr_data[BYTE_W-1:0];
    end else if (pop) begin
      valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/usbfs_bitgen.sv
module usbfs_bitgen
  import usbfs_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int STUFF_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              hold_valid,
  input  logic              hold_sop,
  input  logic [BYTE_W-1:0] hold_byte,
  output logic              pop,
  output tx_cmd_t           cmd,
  output logic              cmd_bit,
  output logic              stuff_ev,
  output logic              eop_ev,
  output logic              drop_ev
);

  localparam int REM_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int ONES_W = $clog2(STUFF_LIMIT + 1);

  tx_phase_t         phase_q, phase_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [ONES_W-1:0] ones_q, ones_d;

  logic stuff_due, byte_done;
  assign stuff_due = (ones_q == ONES_W'(STUFF_LIMIT));
  assign byte_done = (rem_q == '0);

  always_comb begin
    phase_d  = phase_q;
    sh_d     = sh_q;
    rem_d    = rem_q;
    ones_d   = ones_q;
    pop      = 1'b0;
    cmd      = CMD_REST;
    cmd_bit  = 1'b0;
    stuff_ev = 1'b0;
    eop_ev   = 1'b0;
    drop_ev  = 1'b0;
    if (bit_en) begin
      case (phase_q)
        PH_IDLE: begin
          if (hold_valid) begin
            pop = 1'b1;
            if (hold_sop) begin
              cmd     = CMD_BIT;
              cmd_bit = hold_byte[0];
              sh_d    = hold_byte >> 1;
              rem_d   = REM_W'(BYTE_W - 1);
              ones_d  = ONES_W'(ones_after(0, hold_byte[0]));
              phase_d = PH_DATA;
            end else begin
              drop_ev = 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (stuff_due) begin
            cmd      = CMD_BIT;
            cmd_bit  = 1'b0;
            ones_d   = '0;
            stuff_ev = 1'b1;
          end else if (!byte_done) begin
            cmd     = CMD_BIT;
            cmd_bit = sh_q[0];
            sh_d    = sh_q >> 1;
            rem_d   = rem_q - 1'b1;
            ones_d  = ONES_W'(ones_after(int'(ones_q), sh_q[0]));
          end else if (hold_valid) begin
            pop     = 1'b1;
            cmd     = CMD_BIT;
            cmd_bit = hold_byte[0];
            sh_d    = hold_byte >> 1;
            rem_d   = REM_W'(BYTE_W - 1);
            ones_d  = ONES_W'(ones_after(int'(ones_q), hold_byte[0]));
          end else begin
            cmd     = CMD_SE0;
            eop_ev  = 1'b1;
            ones_d  = '0;
            phase_d = PH_SE0B;
          end
        end
        PH_SE0B: begin
          cmd     = CMD_SE0;
          phase_d = PH_JEND;
        end
        default: begin
          cmd     = CMD_JEND;
          phase_d = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= '0;
      rem_q   <= '0;
      ones_q  <= '0;
    end else begin
      phase_q <= phase_d;
      sh_q    <= sh_d;
      rem_q   <= rem_d;
      ones_q  <= ones_d;
    end
  end

endmodule

// File: rtl/usbfs_linecode.sv
module usbfs_linecode
  import usbfs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_en,
  input  logic    low_speed,
  input  tx_cmd_t cmd,
  input  logic    cmd_bit,
  output logic    line_dp,
  output logic    line_dm,
  output logic    line_oe
);

  line_sym_t  level_q, level_d;
  line_sym_t  drive;
  logic       oe_d;
  logic [1:0] pins;

  always_comb begin
    level_d = level_q;
    drive   = SYM_J;
    oe_d    = 1'b1;
    case (cmd)
      CMD_BIT: begin
        level_d = nrzi_step(level_q, cmd_bit);
        drive   = level_d;
      end
      CMD_SE0: drive = SYM_SE0;
      CMD_JEND: begin
        level_d = SYM_J;
        drive   = SYM_J;
      end
      default: begin
        level_d = SYM_J;
        drive   = SYM_J;
        oe_d    = 1'b0;
      end
    endcase
  end

  assign pins = sym_pins(drive, low_speed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= SYM_J;
      line_dp <= 1'b1;
      line_dm <= 1'b0;
      line_oe <= 1'b0;
    end else if (bit_en) begin
      level_q <= level_d;
      line_dp <= pins[1];
      line_dm <= pins[0];
      line_oe <= oe_d;
    end
  end

endmodule

// File: rtl/usbfs_serializer.sv
module usbfs_serializer
  import usbfs_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int STUFF_LIMIT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            low_speed,
  input  logic            wr_en,
  input  logic [BYTE_W:0] wr_data,
  output logic            buf_full,
  output logic            line_dp,
  output logic            line_dm,
  output logic            line_oe
);

  logic              hold_valid, hold_sop, hold_accept, pop;
  logic [BYTE_W-1:0] hold_byte;
  tx_cmd_t           cmd;
  logic              cmd_bit;
  logic              stuff_ev, eop_ev, drop_ev;

  usbfs_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pop     (pop),
    .valid   (hold_valid),
    .sop     (hold_sop),
    .byte_q  (hold_byte),
    .accept  (hold_accept)
  );

  usbfs_bitgen #(.BYTE_W(BYTE_W), .STUFF_LIMIT(STUFF_LIMIT)) u_bitgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .hold_valid (hold_valid),
    .hold_sop   (hold_sop),
    .hold_byte  (hold_byte),
    .pop        (pop),
    .cmd        (cmd),
    .cmd_bit    (cmd_bit),
    .stuff_ev   (stuff_ev),
    .eop_ev     (eop_ev),
    .drop_ev    (drop_ev)
  );

  usbfs_linecode u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .low_speed (low_speed),
    .cmd       (cmd),
    .cmd_bit   (cmd_bit),
    .line_dp   (line_dp),
    .line_dm   (line_dm),
    .line_oe   (line_oe)
  );

  assign buf_full = hold_valid;

endmodule

// File: rtl/usbfs_serializer_sva.sv
module usbfs_serializer_sva #(
  parameter int STUFF_LIMIT = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic wr_en,
  input logic buf_full,
  input logic line_dp,
  input logic line_dm,
  input logic line_oe,
  input logic stuff_ev,
  input logic eop_ev
);

  logic       tick_d;
  logic [1:0] prev_pins;
  int unsigned same_run;
  int unsigned se0_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_d    <= 1'b0;
      prev_pins <= 2'b10;
      same_run  <= 0;
      se0_run   <= 0;
    end else begin
      tick_d <= bit_en;
      if (tick_d) begin
        prev_pins <= {line_dp, line_dm};
        if (line_oe && ({line_dp, line_dm} != 2'b00) && ({line_dp, line_dm} == prev_pins))
          same_run <= same_run + 1;
        else
          same_run <= 0;
        if (line_oe && ({line_dp, line_dm} == 2'b00)) se0_run <= se0_run + 1;
        else                                        se0_run <= 0;
      end
    end
  end

  // R10: outputs move only on a strobe edge
  assert_stable_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({line_dp, line_dm, line_oe}));

  // R4: never more than STUFF_LIMIT bit periods without a transition while driving
  assert_stuff_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    same_run <= STUFF_LIMIT);

  // R4: a stuffed bit flips the line
  assert_stuff_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_ev) |=> (line_dp != $past(line_dp)));

  // R5: end of packet holds SE0 for at most two bit periods
  assert_se0_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    se0_run <= 2);

  // R5: the first SE0 of an end of packet appears on the line
  assert_eop_se0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && eop_ev) |=> (!line_dp && !line_dm && line_oe));

  // R9: the driver releases only after a J period
  assert_release_after_j_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> ($past(line_dp) != $past(line_dm)));

  // R9: SE0 is only ever driven, never idle
  assert_se0_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_dp && !line_dm) |-> line_oe);

  // R8: both lines high never occurs
  assert_no_se1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_dp && line_dm));

  // R6: an accepted write fills the slot
  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !buf_full) |=> buf_full);

endmodule

bind usbfs_serializer usbfs_serializer_sva #(.STUFF_LIMIT(STUFF_LIMIT)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .wr_en    (wr_en),
  .buf_full (buf_full),
  .line_dp  (line_dp),
  .line_dm  (line_dm),
  .line_oe  (line_oe),
  .stuff_ev (stuff_ev),
  .eop_ev   (eop_ev)
);

// File: tb/usbfs_serializer_bench.sv
`timescale 1ns/1ps
module usbfs_serializer_bench;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       low_speed = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       buf_full, line_dp, line_dm, line_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  usbfs_serializer u_usbfs_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .low_speed(low_speed),
    .wr_en(wr_en), .wr_data(wr_data), .buf_full(buf_full),
    .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe)
  );

  // strobe generator
  logic ticks_on = 1'b0;
  int   div_cnt = 0;
  always @(negedge clk) begin
    if (ticks_on) begin
      div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
      bit_en  = (div_cnt == DIV - 1);
    end else begin
      bit_en = 1'b0;
    end
  end

  logic tick_seen = 1'b0;
  always @(posedge clk) tick_seen <= bit_en;

  // capture: 0=J 1=K 2=SE0 3=idle 4=bad idle level 5=bad drive
  int cap [0:1023];
  int cap_n = 0;
  logic [2:0] last_out = 3'b100;
  int between_viol = 0;

  function automatic int decode(logic dp, logic dm, logic oe, logic ls);
    logic [1:0] jp;
    jp = ls ? 2'b01 : 2'b10;
    if (!oe) return ({dp, dm} == jp) ? 3 : 4;
    if ({dp, dm} == 2'b00) return 2;
    if ({dp, dm} == jp) return 0;
    if ({dp, dm} == ~jp) return 1;
    return 5;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (tick_seen) begin
        if (cap_n < 1024) cap[cap_n] = decode(line_dp, line_dm, line_oe, low_speed);
        cap_n = cap_n + 1;
      end else if ({line_dp, line_dm, line_oe} != last_out) begin
        between_viol = between_viol + 1;
      end
      last_out = {line_dp, line_dm, line_oe};
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected stream from the requirements
  int pkt [0:15];
  int pkt_n;
  int exp_s [0:511];
  int exp_n;

  task automatic build_expected();
    int lvl = 0;
    int ones = 0;
    exp_n = 0;
    for (int b = 0; b < pkt_n; b++) begin
      for (int i = 0; i < 8; i++) begin
        int bitv = (pkt[b] >> i) & 1;
        if (bitv == 0) begin lvl = 1 - lvl; ones = 0; end   // R3
        else ones = ones + 1;
        exp_s[exp_n] = lvl; exp_n = exp_n + 1;
        if (ones == 6) begin                                 // R4
          lvl = 1 - lvl; ones = 0;
          exp_s[exp_n] = lvl; exp_n = exp_n + 1;
        end
      end
    end
    exp_s[exp_n] = 2; exp_s[exp_n + 1] = 2; exp_s[exp_n + 2] = 0;  // R5
    exp_s[exp_n + 3] = 3;                                            // R9
    exp_n = exp_n + 4;
  endtask

  task automatic write_word(input logic [8:0] w);
    while (buf_full) @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic compare_stream(input string req);
    int idx = 0;
    int bad = -1;
    while (idx < cap_n && idx < 1024 && cap[idx] == 3) idx++;
    for (int k = 0; k < exp_n; k++)
      if (bad < 0 && (idx + k >= cap_n || cap[idx + k] != exp_s[k])) bad = k;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, (idx + bad < cap_n) ? cap[idx + bad] : -1, exp_s[bad]);
  endtask

  task automatic run_packet(input string req);
    build_expected();
    cap_n = 0;
    for (int b = 0; b < pkt_n; b++) write_word((b == 0) ? (9'h100 | pkt[b][7:0]) : {1'b0, pkt[b][7:0]});
    repeat ((exp_n + 8) * DIV) @(negedge clk);
    compare_stream(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(line_dp == 1'b1, "R1 dp", line_dp, 1);
    check(line_dm == 1'b0, "R1 dm", line_dm, 0);
    check(line_oe == 1'b0, "R1 oe", line_oe, 0);
    check(buf_full == 1'b0, "R1 buf_full", buf_full, 0);

    ticks_on = 1'b1;
    repeat (4 * DIV) @(negedge clk);

    // R2: sync alone, K J K J K J K K then end of packet
    pkt[0] = 8'h80; pkt_n = 1;
    run_packet("R2 sync only");
    begin
      int idx = 0;
      while (cap[idx] == 3) idx++;
      check(cap[idx] == 1 && cap[idx + 1] == 0 && cap[idx + 6] == 1 && cap[idx + 7] == 1,
            "R2 sync pattern", cap[idx + 7], 1);
    end

    // R3/R4/R5/R9: sweep every data byte behind sync
    for (int v = 0; v < 256; v++) begin
      pkt[0] = 8'h80; pkt[1] = v; pkt_n = 2;
      run_packet("R3 R4 R5 R9 byte sweep");
    end

    // R4: stuffing across byte boundaries
    pkt[0] = 8'h80; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'hFF; pkt[4] = 8'hFF; pkt_n = 5;
    run_packet("R4 ones run");
    pkt[0] = 8'h80; pkt[1] = 8'hE0; pkt[2] = 8'h07; pkt[3] = 8'hFE; pkt[4] = 8'h3F; pkt_n = 5;
    run_packet("R4 boundary run");
    pkt[0] = 8'h80; pkt[1] = 8'h00; pkt[2] = 8'h01; pkt[3] = 8'h02; pkt[4] = 8'h03; pkt_n = 5;
    run_packet("R3 multi byte");

    // R6: buf_full and ignored write while full
    ticks_on = 1'b0;
    @(negedge clk);
    write_word(9'h180);
    check(buf_full == 1'b1, "R6 full after write", buf_full, 1);
    wr_en = 1'b1; wr_data = 9'h0AA;
    @(negedge clk);
    wr_en = 1'b0;
    check(buf_full == 1'b1, "R6 still full", buf_full, 1);
    pkt[0] = 8'h80; pkt_n = 1;
    build_expected();
    cap_n = 0;
    ticks_on = 1'b1;
    repeat (2 * DIV) @(negedge clk);
    check(buf_full == 1'b0, "R6 drained", buf_full, 0);
    repeat ((exp_n + 8) * DIV) @(negedge clk);
    compare_stream("R6 ignored write absent");

    // R7: non-start write while idle is dropped
    ticks_on = 1'b0;
    @(negedge clk);
    write_word(9'h055);
    check(buf_full == 1'b1, "R7 slot taken", buf_full, 1);
    cap_n = 0;
    ticks_on = 1'b1;
    repeat (6 * DIV) @(negedge clk);
    check(buf_full == 1'b0, "R7 dropped", buf_full, 0);
    begin
      int act = 0;
      for (int k = 0; k < cap_n; k++) if (cap[k] != 3) act++;
      check(act == 0, "R7 line quiet", act, 0);
    end

    // R8: low-speed polarity
    low_speed = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    check(line_dp == 1'b0 && line_dm == 1'b1, "R8 idle low speed", {line_dp, line_dm}, 1);
    pkt[0] = 8'h80; pkt[1] = 8'hFF; pkt[2] = 8'h5A; pkt_n = 3;
    run_packet("R8 low speed packet");
    low_speed = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    check(line_dp == 1'b1 && line_dm == 1'b0, "R8 idle full speed", {line_dp, line_dm}, 2);

    // R10: no output change between strobes
    check(between_viol == 0, "R10 stable between strobes", between_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule